// File: doc/BRIEF.md
# Upset-Tolerant Boundary-Scan Test Access Controller

This block is the sixteen-state test access port controller of a chip's boundary-scan logic. It has a 5-bit instruction register and a one-bit bypass path. A scrub sequencer is wrapped around it. The controller state lives in a 4-bit binary register. A radiation upset in that register can throw the controller into any state, including Update-IR, and that state could then apply a pin-driving instruction.

To bound the harm, the sequencer ORs a logic one into the mode-select line for a fixed burst of test-clock edges. A burst is started by a one-cycle recover request or by a free-running scrub interval. Five such edges bring the controller to Test-Logic-Reset from any state. While in Test-Logic-Reset, the instruction register refills with all ones, which selects bypass.

The external boundary cells receive decoded capture, shift and update strobes. They return their serial data on a dedicated input. The block has no streaming data path: every pin is a plain control or status signal, so no valid/ready handshake applies.

Top module: `jtag_tap_guard`

## Requirements
- R1: While `test_rst_n` is low, the controller is asynchronously placed in Test-Logic-Reset (code 4'hF). In that state `bypass_on`=1, `extest_on`=0, `scan_out`=1, `scan_out_en`=0 and `guard_busy`=0.
- R2: On each rising test-clock edge the state follows the standard sixteen-state graph, steered by the effective mode-select bit. `state_out` uses these codes: Test-Logic-Reset F, Run-Test/Idle C, Select-DR 7, Capture-DR 6, Shift-DR 2, Exit1-DR 1, Pause-DR 3, Exit2-DR 0, Update-DR 5, Select-IR 4, Capture-IR E, Shift-IR A, Exit1-IR 9, Pause-IR B, Exit2-IR 8, Update-IR D.
- R3: From every one of the sixteen states, five rising edges with mode-select high leave the controller in Test-Logic-Reset.
- R4: A `recover_req` high at a rising edge raises `guard_busy` for the next five edges. During those edges the effective mode-select is 1 whatever `mode_sel_in` is, so the controller ends in Test-Logic-Reset.
- R5: When `SCRUB_PERIOD` is nonzero, every `SCRUB_PERIOD`-th rising edge after reset starts the same five-edge burst with no request. A value of 0 disables the interval.
- R6: On each falling edge spent in Test-Logic-Reset, the instruction register is loaded with 5'b11111, which selects bypass and clears `extest_on`.
- R7: Capture-IR loads the instruction shift stage with 5'b00001. In Shift-IR that stage shifts toward bit 0, with `scan_in` entering at bit 4, and bit 0 is presented first on `scan_out`.
- R8: The active instruction changes only on the falling edge of the clock while in Update-IR. Passing through any other IR state leaves it untouched.
- R9: Instruction 5'b00000 raises `extest_on` and 5'b00010 raises `sample_on`. Every other code raises `bypass_on`. Exactly one of the three is high at any time.
- R10: With bypass selected, Capture-DR clears the one-bit bypass stage. In Shift-DR, `scan_out` then repeats `scan_in` one edge later.
- R11: `scan_out` and `scan_out_en` change on falling edges. In Shift-IR or Shift-DR the enable is 1 and the data bit is driven. In every other state the enable is 0 and the data is 1.
- R12: `bsr_capture`, `bsr_shift` and `bsr_update` are high in Capture-DR, Shift-DR and Update-DR respectively, but only while EXTEST or SAMPLE is selected. In Shift-DR with such a selection, `scan_out` carries `bsr_ret`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| test_clk | input | 1 | Test clock |
| test_rst_n | input | 1 | Asynchronous reset, active low |
| mode_sel_in | input | 1 | Mode-select bit steering the state graph |
| scan_in | input | 1 | Serial test data input |
| recover_req | input | 1 | One-cycle request for a forced-high burst |
| bsr_ret | input | 1 | Serial data returned by external boundary cells |
| scan_out | output | 1 | Serial test data output, falling-edge timed |
| scan_out_en | output | 1 | High while `scan_out` carries shift data |
| state_out | output | 4 | Current controller state code |
| extest_on | output | 1 | EXTEST instruction active (pins driven) |
| sample_on | output | 1 | SAMPLE instruction active |
| bypass_on | output | 1 | Bypass instruction active |
| bsr_capture | output | 1 | Boundary cells capture strobe |
| bsr_shift | output | 1 | Boundary cells shift enable |
| bsr_update | output | 1 | Boundary cells update strobe |
| guard_busy | output | 1 | Forced mode-select burst in progress |

## Verification
The properties assume that reset is released away from both clock edges. They also assume that `mode_sel_in`, `scan_in`, `recover_req` and `bsr_ret` hold steady across each rising edge and the falling edge after it, because the instruction register and the serial output are timed on the falling edge. The stimulus changes every input a quarter period after a falling edge and holds it for a full period. It releases reset at that same point, so no rising or falling edge ever sees an input in motion. `recover_req` is applied as a one-edge pulse.

// File: rtl/tapg_pkg.sv
package tapg_pkg;

  typedef enum logic [3:0] {
    ST_RESET   = 4'hF,
    ST_IDLE    = 4'hC,
    ST_SEL_DR  = 4'h7,
    ST_CAP_DR  = 4'h6,
    ST_SH_DR   = 4'h2,
    ST_EX1_DR  = 4'h1,
    ST_PAU_DR  = 4'h3,
    ST_EX2_DR  = 4'h0,
    ST_UPD_DR  = 4'h5,
    ST_SEL_IR  = 4'h4,
    ST_CAP_IR  = 4'hE,
    ST_SH_IR   = 4'hA,
    ST_EX1_IR  = 4'h9,
    ST_PAU_IR  = 4'hB,
    ST_EX2_IR  = 4'h8,
    ST_UPD_IR  = 4'hD
  } tap_state_e;

  function automatic tap_state_e tap_next(input tap_state_e cur, input logic hi);
    tap_state_e nxt;
    case (cur)
      ST_RESET:  nxt = hi ? ST_RESET  : ST_IDLE;
      ST_IDLE:   nxt = hi ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: nxt = hi ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: nxt = hi ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  nxt = hi ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: nxt = hi ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: nxt = hi ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: nxt = hi ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: nxt = hi ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: nxt = hi ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR: nxt = hi ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  nxt = hi ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: nxt = hi ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: nxt = hi ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: nxt = hi ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: nxt = hi ? ST_SEL_DR : ST_IDLE;
      default:   nxt = ST_RESET;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/tapg_fsm.sv
module tapg_fsm
  import tapg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_eff,
  output tap_state_e state
);

  tap_state_e state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_RESET;
    else        state_q <= tap_next(state_q, mode_eff);
  end

  assign state = state_q;

endmodule

// File: rtl/tapg_scrub.sv
module tapg_scrub #(
  parameter int BURST_LEN    = 5,
  parameter int SCRUB_PERIOD = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic recover_req,
  output logic busy
);

  localparam int BW = $clog2(BURST_LEN + 1);

  logic [BW-1:0] left_q;
  logic          period_hit;

  generate
    if (SCRUB_PERIOD > 0) begin : g_interval
      localparam int PW = (SCRUB_PERIOD > 1) ? $clog2(SCRUB_PERIOD) : 1;
      localparam logic [PW-1:0] LAST = PW'(SCRUB_PERIOD - 1);
      logic [PW-1:0] tick_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              tick_q <= '0;
        else if (tick_q == LAST) tick_q <= '0;
        else                     tick_q <= tick_q + 1'b1;
      end

      assign period_hit = (tick_q == LAST);
    end else begin : g_no_interval
      assign period_hit = 1'b0;
    end
  endgenerate

  // A new trigger reloads the burst, so a request during a burst extends it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        left_q <= '0;
    else if (recover_req || period_hit) left_q <= BW'(BURST_LEN);
    else if (left_q != '0)             left_q <= left_q - 1'b1;
  end

  assign busy = (left_q != '0);

endmodule

// File: rtl/tapg_ir.sv
module tapg_ir
  import tapg_pkg::*;
#(
  parameter int              IR_W        = 5,
  parameter logic [IR_W-1:0] CAPTURE_PAT = 5'b00001
) (
  input  logic            clk,
  input  logic            rst_n,
  input  tap_state_e      state,
  input  logic            sdi,
  output logic [IR_W-1:0] instr,
  output logic            shift_lsb
);

  localparam logic [IR_W-1:0] ALL_ONES = '1;

  logic [IR_W-1:0] shreg_q;
  logic [IR_W-1:0] instr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    shreg_q <= ALL_ONES;
    else if (state == ST_CAP_IR)   shreg_q <= CAPTURE_PAT;
    else if (state == ST_SH_IR)    shreg_q <= {sdi, shreg_q[IR_W-1:1]};
  end

  // Active instruction: falling-edge timed, refilled with ones in reset state.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n)                    instr_q <= ALL_ONES;
    else if (state == ST_RESET)    instr_q <= ALL_ONES;
    else if (state == ST_UPD_IR)   instr_q <= shreg_q;
  end

  assign instr     = instr_q;
  assign shift_lsb = shreg_q[0];

endmodule

// File: rtl/jtag_tap_guard.sv
module jtag_tap_guard
  import tapg_pkg::*;
#(
  parameter int              IR_W         = 5,
  parameter logic [IR_W-1:0] CAPTURE_PAT  = 5'b00001,
  parameter logic [IR_W-1:0] OP_EXTEST    = 5'b00000,
  parameter logic [IR_W-1:0] OP_SAMPLE    = 5'b00010,
  parameter int              BURST_LEN    = 5,
  parameter int              SCRUB_PERIOD = 4096
) (
  input  logic       test_clk,
  input  logic       test_rst_n,
  input  logic       mode_sel_in,
  input  logic       scan_in,
  input  logic       recover_req,
  input  logic       bsr_ret,
  output logic       scan_out,
  output logic       scan_out_en,
  output logic [3:0] state_out,
  output logic       extest_on,
  output logic       sample_on,
  output logic       bypass_on,
  output logic       bsr_capture,
  output logic       bsr_shift,
  output logic       bsr_update,
  output logic       guard_busy
);

  tap_state_e      state;
  logic            mode_eff;
  logic [IR_W-1:0] instr;
  logic            ir_lsb;
  logic            byp_q;
  logic            bsr_sel;
  logic            sdo_q;
  logic            sdo_en_q;

  tapg_scrub #(
    .BURST_LEN   (BURST_LEN),
    .SCRUB_PERIOD(SCRUB_PERIOD)
  ) u_scrub (
    .clk        (test_clk),
    .rst_n      (test_rst_n),
    .recover_req(recover_req),
    .busy       (guard_busy)
  );

  assign mode_eff = mode_sel_in | guard_busy;

  tapg_fsm u_fsm (
    .clk     (test_clk),
    .rst_n   (test_rst_n),
    .mode_eff(mode_eff),
    .state   (state)
  );

  tapg_ir #(
    .IR_W       (IR_W),
    .CAPTURE_PAT(CAPTURE_PAT)
  ) u_ir (
    .clk      (test_clk),
    .rst_n    (test_rst_n),
    .state    (state),
    .sdi      (scan_in),
    .instr    (instr),
    .shift_lsb(ir_lsb)
  );

  assign extest_on = (instr == OP_EXTEST);
  assign sample_on = (instr == OP_SAMPLE);
  assign bypass_on = !(extest_on || sample_on);
  assign bsr_sel   = extest_on || sample_on;

  assign bsr_capture = bsr_sel && (state == ST_CAP_DR);
  assign bsr_shift   = bsr_sel && (state == ST_SH_DR);
  assign bsr_update  = bsr_sel && (state == ST_UPD_DR);

  always_ff @(posedge test_clk or negedge test_rst_n) begin
    if (!test_rst_n)               byp_q <= 1'b0;
    else if (state == ST_CAP_DR)   byp_q <= 1'b0;
    else if (state == ST_SH_DR)    byp_q <= scan_in;
  end

  always_ff @(negedge test_clk or negedge test_rst_n) begin
    if (!test_rst_n) begin
      sdo_q    <= 1'b1;
      sdo_en_q <= 1'b0;
    end else if (state == ST_SH_IR) begin
      sdo_q    <= ir_lsb;
      sdo_en_q <= 1'b1;
    end else if (state == ST_SH_DR) begin
      sdo_q    <= bsr_sel ? bsr_ret : byp_q;
      sdo_en_q <= 1'b1;
    end else begin
      sdo_q    <= 1'b1;
      sdo_en_q <= 1'b0;
    end
  end

  assign scan_out    = sdo_q;
  assign scan_out_en = sdo_en_q;
  assign state_out   = state;

endmodule

// File: rtl/tapg_checker.sv
module tapg_checker
  import tapg_pkg::*;
(
  input logic       test_clk,
  input logic       test_rst_n,
  input logic       mode_sel_in,
  input logic [3:0] state_out,
  input logic       extest_on,
  input logic       sample_on,
  input logic       bypass_on,
  input logic       scan_out,
  input logic       scan_out_en,
  input logic       guard_busy
);

  AST_ONE_INSTR: assert property (@(posedge test_clk) disable iff (!test_rst_n)
    $countones({extest_on, sample_on, bypass_on}) == 1); // R9

  AST_BURST_ENDS_RESET: assert property (@(posedge test_clk) disable iff (!test_rst_n)
    $fell(guard_busy) |-> state_out == 4'hF); // R4

  AST_RESET_HOLD: assert property (@(posedge test_clk) disable iff (!test_rst_n)
    (state_out == 4'hF && mode_sel_in) |=> state_out == 4'hF); // R2

  AST_INSTR_STABLE: assert property (@(negedge test_clk) disable iff (!test_rst_n)
    (state_out != 4'hD && state_out != 4'hF) |=> $stable({extest_on, sample_on, bypass_on})); // R8

  AST_OUT_IDLE: assert property (@(posedge test_clk) disable iff (!test_rst_n)
    !scan_out_en |-> scan_out); // R11

endmodule

bind jtag_tap_guard tapg_checker u_chk (
  .test_clk   (test_clk),
  .test_rst_n (test_rst_n),
  .mode_sel_in(mode_sel_in),
  .state_out  (state_out),
  .extest_on  (extest_on),
  .sample_on  (sample_on),
  .bypass_on  (bypass_on),
  .scan_out   (scan_out),
  .scan_out_en(scan_out_en),
  .guard_busy (guard_busy)
);

// File: tb/jtag_tap_guard_test.sv
module jtag_tap_guard_test;

  localparam int CLK_PERIOD = 20;
  localparam int PER_SCRUB  = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode = 1'b1;
  logic sdi = 1'b0;
  logic rec = 1'b0;
  logic ret = 1'b0;

  logic       sdo, sdo_en, ext, sam, byp, cap, shf, upd, busy;
  logic [3:0] st;
  logic       p_sdo, p_sdo_en, p_ext, p_sam, p_byp, p_cap, p_shf, p_upd, p_busy;
  logic [3:0] p_st;

  int compared = 0;
  int mismatched = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  jtag_tap_guard #(.SCRUB_PERIOD(0)) uut (
    .test_clk(clk), .test_rst_n(rst_n), .mode_sel_in(mode), .scan_in(sdi),
    .recover_req(rec), .bsr_ret(ret), .scan_out(sdo), .scan_out_en(sdo_en),
    .state_out(st), .extest_on(ext), .sample_on(sam), .bypass_on(byp),
    .bsr_capture(cap), .bsr_shift(shf), .bsr_update(upd), .guard_busy(busy)
  );

  jtag_tap_guard #(.SCRUB_PERIOD(PER_SCRUB)) uut_per (
    .test_clk(clk), .test_rst_n(rst_n), .mode_sel_in(mode), .scan_in(sdi),
    .recover_req(1'b0), .bsr_ret(ret), .scan_out(p_sdo), .scan_out_en(p_sdo_en),
    .state_out(p_st), .extest_on(p_ext), .sample_on(p_sam), .bypass_on(p_byp),
    .bsr_capture(p_cap), .bsr_shift(p_shf), .bsr_update(p_upd), .guard_busy(p_busy)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // One rising edge and the falling edge after it; sample a quarter period later.
  task automatic tick(input logic m, input logic d);
    mode = m;
    sdi  = d;
    @(posedge clk);
    @(negedge clk);
    #(CLK_PERIOD/4);
  endtask

  task automatic do_reset();
    @(negedge clk);
    #(CLK_PERIOD/4);
    rst_n = 1'b0;
    mode  = 1'b1;
    rec   = 1'b0;
    #(CLK_PERIOD*2);
    rst_n = 1'b1;
  endtask

  // From Run-Test/Idle, load an instruction and return to Run-Test/Idle.
  task automatic load_ir(input logic [4:0] v);
    tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
    for (int k = 0; k < 5; k++) tick(k == 4, v[k]);
    tick(1, 0); tick(0, 0);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 state", st, 4'hF);
    chk("R1 bypass", byp, 1);
    chk("R1 extest", ext, 0);
    chk("R1 sdo", sdo, 1);
    chk("R1 sdo_en", sdo_en, 0);
    chk("R1 busy", busy, 0);
  endtask

  task automatic t_walk();
    string      path [16];
    logic [3:0] code [16];
    path[0]  = "";        code[0]  = 4'hF;
    path[1]  = "0";       code[1]  = 4'hC;
    path[2]  = "01";      code[2]  = 4'h7;
    path[3]  = "010";     code[3]  = 4'h6;
    path[4]  = "0100";    code[4]  = 4'h2;
    path[5]  = "0101";    code[5]  = 4'h1;
    path[6]  = "01010";   code[6]  = 4'h3;
    path[7]  = "010101";  code[7]  = 4'h0;
    path[8]  = "01011";   code[8]  = 4'h5;
    path[9]  = "011";     code[9]  = 4'h4;
    path[10] = "0110";    code[10] = 4'hE;
    path[11] = "01100";   code[11] = 4'hA;
    path[12] = "01101";   code[12] = 4'h9;
    path[13] = "011010";  code[13] = 4'hB;
    path[14] = "0110101"; code[14] = 4'h8;
    path[15] = "011011";  code[15] = 4'hD;
    for (int i = 0; i < 16; i++) begin
      do_reset();
      for (int k = 0; k < path[i].len(); k++) tick(path[i][k] == "1", 0);
      chk("R2 state code", st, code[i]);
      for (int k = 0; k < 5; k++) tick(1, 0);
      chk("R3 back to reset", st, 4'hF);
    end
  endtask

  task automatic t_ir();
    do_reset();
    tick(0, 0);
    tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
    chk("R7 capture bit0", sdo, 1);
    chk("R11 en in shift-ir", sdo_en, 1);
    for (int k = 0; k < 5; k++) begin
      tick(k == 4, 0);
      if (k < 4) chk("R7 capture upper bit", sdo, 0);
    end
    chk("R11 idle after shift", sdo, 1);
    chk("R11 en after shift", sdo_en, 0);
    chk("R8 no change in exit1", ext, 0);
    mode = 1;
    @(posedge clk);
    #(CLK_PERIOD/4);
    chk("R8 state update-ir", st, 4'hD);
    chk("R8 before falling edge", ext, 0);
    @(negedge clk);
    #(CLK_PERIOD/4);
    chk("R9 extest decoded", ext, 1);
    chk("R9 bypass off", byp, 0);
    tick(0, 0);
    chk("R9 extest held in idle", ext, 1);
  endtask

  task automatic t_recover();
    // Continues from t_ir: EXTEST active, Run-Test/Idle.
    rec = 1;
    tick(0, 0);
    rec = 0;
    chk("R4 busy raised", busy, 1);
    chk("R4 state kept", st, 4'hC);
    for (int k = 0; k < 5; k++) tick(0, 0);
    chk("R4 reset reached", st, 4'hF);
    chk("R4 busy dropped", busy, 0);
    chk("R6 extest cleared", ext, 0);
    chk("R6 bypass selected", byp, 1);
  endtask

  task automatic t_bypass();
    logic [7:0] pat = 8'b1011_0010;
    do_reset();
    tick(0, 0); tick(1, 0); tick(0, 0);
    chk("R12 no bsr capture in bypass", cap, 0);
    tick(0, 1);
    chk("R10 captured zero", sdo, 0);
    chk("R12 no bsr shift in bypass", shf, 0);
    for (int k = 0; k < 8; k++) begin
      tick(k == 7, pat[k]);
      if (k < 7) chk("R10 one-stage delay", sdo, pat[k]);
    end
    chk("R11 idle in exit1-dr", sdo, 1);
    chk("R11 en off in exit1-dr", sdo_en, 0);
  endtask

  task automatic t_sample();
    logic [3:0] pat = 4'b0110;
    do_reset();
    tick(0, 0);
    load_ir(5'b00010);
    chk("R9 sample decoded", sam, 1);
    tick(1, 0); tick(0, 0);
    chk("R12 bsr capture", cap, 1);
    for (int k = 0; k < 4; k++) begin
      ret = pat[k];
      tick(0, 0);
      chk("R12 bsr shift", shf, 1);
      chk("R12 return data on out", sdo, pat[k]);
    end
    tick(1, 0); tick(1, 0);
    chk("R12 bsr update", upd, 1);
    tick(0, 0);
    load_ir(5'b10101);
    chk("R9 unknown is bypass", byp, 1);
    chk("R9 sample off", sam, 0);
  endtask

  task automatic t_periodic();
    do_reset();
    for (int n = 1; n <= PER_SCRUB + 6; n++) begin
      tick(0, 0);
      if (n == PER_SCRUB - 1) chk("R5 quiet before interval", p_busy, 0);
      if (n == PER_SCRUB) begin
        chk("R5 interval burst", p_busy, 1);
        chk("R5 idle at trigger", p_st, 4'hC);
      end
      if (n == PER_SCRUB + 5) begin
        chk("R5 reset after burst", p_st, 4'hF);
        chk("R5 burst done", p_busy, 0);
      end
      if (n == PER_SCRUB + 6) chk("R5 resumes", p_st, 4'hC);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    mismatched++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    t_reset();
    t_walk();
    t_ir();
    t_recover();
    t_bypass();
    t_sample();
    t_periodic();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule